// File: doc/BRIEF.md
# Configurable Bit-Serial Round-Key Generator

This block produces the round keys of a lightweight Feistel block cipher one bit per clock, least significant bit first. It runs in lockstep with a bit-serial round datapath. A 4-bit configuration index selects the word size n (16, 24, 32, 48 or 64 bits), the number of key words m (2, 3 or 4) and the number of rounds. The master key is shifted in serially. A start pulse then launches the schedule. For each round the block streams out the current key word and computes the next word from the stored words and a one-bit round constant supplied from outside.

Key words live in four word groups. Each group is a serial store whose active length follows n. Only m groups are active: groups 0 and 3 always, group 2 when m is 3 or more, and group 1 when m is 4. A small 4-bit buffer keeps the low bits of the newest word so that the rotate-right reads near the end of a round still see the old word. A 1-bit buffer does the same job for group 1 when m is 4. The block also reports which of five constant sequences the selected configuration needs, so the constant source can be pointed at the right one.

Top module: `serial_key_sched`

## Requirements
- R1: After reset, busy_o, rk_bit_o, round_o and bit_idx_o are all 0.
- R2: While idle with load_i high, one key bit per cycle is taken from key_bit_i. The key is sent as m*n bits: word 0 bit 0 first, through to word m-1 bit n-1.
- R3: cfg_i maps to (n, m, rounds, sequence) as follows: 0 gives 16,4,32,0; 1 gives 24,3,36,0; 2 gives 24,4,36,1; 3 gives 32,3,42,2; 4 gives 32,4,44,3; 5 gives 48,2,52,2; 6 gives 48,3,54,3; 7 gives 64,2,68,2; 8 gives 64,3,69,3; 9 gives 64,4,72,4. Codes 10 to 15 act as code 0. The sequence number appears on zsel_o.
- R4: A start_i pulse while idle raises busy_o on the next edge with bit_idx_o=0 and round_o=0. After that, bit_idx_o counts 0..n-1 and round_o advances by one each time bit_idx_o wraps.
- R5: In rounds 0..m-1, rk_bit_o carries bit bit_idx_o of loaded word round_o.
- R6: For m=2 and m=3, word k[i+m] equals rotr3(k[i+m-1]) ^ rotr4(k[i+m-1]) ^ k[i] ^ C ^ z, where C = 2^n-4.
- R7: For m=4, word k[i+4] equals rotr3(k[i+3]) ^ rotr4(k[i+3]) ^ k[i+1] ^ rotr1(k[i+1]) ^ k[i] ^ C ^ z.
- R8: z_i is sampled only in the cycle where bit_idx_o=0, and its value in round i goes into bit 0 of k[i+m]. Its value at any other bit position has no effect.
- R9: The edge after the last bit of round rounds-1, busy_o drops. round_o then holds rounds-1 and bit_idx_o returns to 0.
- R10: While busy_o is high, load_i, key_bit_i and start_i have no effect on the key stream or on the round and bit counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 4 | Configuration index |
| load_i | input | 1 | Serial key load enable |
| key_bit_i | input | 1 | Serial key data |
| start_i | input | 1 | Start the schedule |
| z_i | input | 1 | Round-constant bit for the current round |
| rk_bit_o | output | 1 | Round-key bit, LSB first |
| bit_idx_o | output | 7 | Bit position of rk_bit_o |
| round_o | output | 7 | Round index of rk_bit_o |
| busy_o | output | 1 | Schedule running |
| zsel_o | output | 3 | Constant sequence the configuration needs |

## Verification
The sequencing properties assume that cfg_i does not change from the start of a key load until busy_o falls. The round length and round count are read from it on every cycle. The stimulus changes the configuration only between runs, and always before the key for the next run is loaded. The recurrence properties also assume that z_i is valid in the cycle where bit_idx_o is 0. The stimulus derives z_i from the round number at that position and drives unrelated values at every other position. During some runs it also toggles load_i, key_bit_i and start_i, to show that these inputs are ignored while busy_o is high.

// File: rtl/ks_pkg.sv
package ks_pkg;
  localparam int WORD_MAX = 64;
  localparam int IDX_W    = 7;
  localparam int CFG_W    = 4;
  localparam int TAP_N    = 5;
  localparam int GRP_N    = 4;

  typedef struct packed {
    logic [IDX_W-1:0] len;
    logic [2:0]       m;
    logic [IDX_W-1:0] rounds;
    logic [2:0]       zsel;
  } ks_cfg_t;

  function automatic ks_cfg_t decode_cfg(logic [CFG_W-1:0] c);
    ks_cfg_t r;
    case (c)
      4'd1:    r = '{len: 7'd24, m: 3'd3, rounds: 7'd36, zsel: 3'd0};
      4'd2:    r = '{len: 7'd24, m: 3'd4, rounds: 7'd36, zsel: 3'd1};
      4'd3:    r = '{len: 7'd32, m: 3'd3, rounds: 7'd42, zsel: 3'd2};
      4'd4:    r = '{len: 7'd32, m: 3'd4, rounds: 7'd44, zsel: 3'd3};
      4'd5:    r = '{len: 7'd48, m: 3'd2, rounds: 7'd52, zsel: 3'd2};
      4'd6:    r = '{len: 7'd48, m: 3'd3, rounds: 7'd54, zsel: 3'd3};
      4'd7:    r = '{len: 7'd64, m: 3'd2, rounds: 7'd68, zsel: 3'd2};
      4'd8:    r = '{len: 7'd64, m: 3'd3, rounds: 7'd69, zsel: 3'd3};
      4'd9:    r = '{len: 7'd64, m: 3'd4, rounds: 7'd72, zsel: 3'd4};
      default: r = '{len: 7'd16, m: 3'd4, rounds: 7'd32, zsel: 3'd0};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ks_word_sreg.sv
module ks_word_sreg #(
  parameter int W     = 64,
  parameter int LEN_W = 7,
  parameter int TAPS  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             bit_i,
  output logic [TAPS-1:0]  tap_o
);
  logic [W-1:0] q, nxt;

  // shift toward bit 0, new bit enters at position len-1
  for (genvar g = 0; g < W; g++) begin : g_bit
    if (g == W-1) begin : g_top
      assign nxt[g] = (int'(len_i) == W) ? bit_i : 1'b0;
    end else begin : g_mid
      assign nxt[g] = (g == int'(len_i) - 1) ? bit_i :
                      (g <  int'(len_i) - 1) ? q[g+1] : 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (en_i) q <= nxt;
  end

  assign tap_o = q[TAPS-1:0];

  AST_STORE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q)); // R10
endmodule

// File: rtl/ks_ctrl.sv
module ks_ctrl #(
  parameter int IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] len_i,
  input  logic [IDX_W-1:0] rounds_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] round_o
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q, round_q;
  logic             last_bit, last_round;

  assign last_bit   = idx_q == len_i - IDX_W'(1);
  assign last_round = round_q == rounds_i - IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      round_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        round_q <= '0;
      end
    end else if (last_bit) begin
      idx_q <= '0;
      if (last_round) busy_q  <= 1'b0;
      else            round_q <= round_q + IDX_W'(1);
    end else begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign busy_o  = busy_q;
  assign idx_o   = idx_q;
  assign round_o = round_q;

  AST_START_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> (busy_q && idx_q == '0 && round_q == '0)); // R4
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_bit) |=> (busy_q && idx_q == $past(idx_q) + IDX_W'(1) && $stable(round_q))); // R4
  AST_ROUND_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && last_bit && !last_round) |=> (busy_q && idx_q == '0 && round_q == $past(round_q) + IDX_W'(1))); // R4
  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> idx_q < len_i); // R4
  AST_DONE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && last_bit && last_round) |=> (!busy_q && idx_q == '0 && $stable(round_q))); // R9
  AST_IDLE_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> (!busy_q && $stable(round_q))); // R9
endmodule

// File: rtl/ks_mix.sv
module ks_mix #(
  parameter int IDX_W = 7
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] len_i,
  input  logic             wide_i,
  input  logic             z_i,
  input  logic             low_i,
  input  logic             top3_i,
  input  logic             top4_i,
  input  logic [3:0]       sav_top_i,
  input  logic             g1_0_i,
  input  logic             g1_1_i,
  input  logic             sav_g1_i,
  output logic             bit_o
);
  logic [IDX_W-1:0] i1, i3, i4, d3, d4;
  logic             a3, a4, k1n, cbit;

  always_comb begin
    i1 = idx_i + IDX_W'(1);
    i3 = idx_i + IDX_W'(3);
    i4 = idx_i + IDX_W'(4);
    d3 = i3 - len_i;
    d4 = i4 - len_i;
    // past the end of the word the wrapped bits come from the saved low bits
    a3  = (i3 < len_i) ? top3_i : sav_top_i[d3[1:0]];
    a4  = (i4 < len_i) ? top4_i : sav_top_i[d4[1:0]];
    k1n = (i1 < len_i) ? g1_1_i : sav_g1_i;
    // constant 2^n-4 plus round bit at position 0
    cbit  = (idx_i >= IDX_W'(2)) ? 1'b1 : ((idx_i == '0) ? z_i : 1'b0);
    bit_o = a3 ^ a4 ^ low_i ^ cbit ^ (wide_i ? (g1_0_i ^ k1n) : 1'b0);
  end
endmodule

// File: rtl/serial_key_sched.sv
module serial_key_sched
  import ks_pkg::*;
#(
  parameter int WORD_W = ks_pkg::WORD_MAX
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             load_i,
  input  logic             key_bit_i,
  input  logic             start_i,
  input  logic             z_i,
  output logic             rk_bit_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic [IDX_W-1:0] round_o,
  output logic             busy_o,
  output logic [2:0]       zsel_o
);
  ks_cfg_t          cfg;
  logic             busy, shift_ld, new_bit, wide;
  logic [IDX_W-1:0] idx;
  logic [GRP_N-1:0] grp_en, grp_in;
  logic [TAP_N-1:0] tap [GRP_N];
  logic [3:0]       sav_top_q;
  logic             sav_g1_q;

  assign cfg      = decode_cfg(cfg_i);
  assign wide     = cfg.m == 3'd4;
  assign shift_ld = load_i && !busy;

  ks_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .clk_i, .rst_ni, .start_i,
    .len_i(cfg.len), .rounds_i(cfg.rounds),
    .busy_o(busy), .idx_o(idx), .round_o(round_o)
  );

  // group 3 is always the newest word, group 0 the current round key
  always_comb begin
    grp_en    = '0;
    grp_en[0] = busy || shift_ld;
    grp_en[3] = busy || shift_ld;
    grp_en[2] = (busy || shift_ld) && cfg.m >= 3'd3;
    grp_en[1] = (busy || shift_ld) && wide;
    grp_in[3] = busy ? new_bit : key_bit_i;
    grp_in[2] = tap[3][0];
    grp_in[1] = tap[2][0];
    case (cfg.m)
      3'd2:    grp_in[0] = tap[3][0];
      3'd3:    grp_in[0] = tap[2][0];
      default: grp_in[0] = tap[1][0];
    endcase
  end

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    ks_word_sreg #(.W(WORD_W), .LEN_W(IDX_W), .TAPS(TAP_N)) i_word (
      .clk_i, .rst_ni,
      .en_i(grp_en[g]), .len_i(cfg.len), .bit_i(grp_in[g]), .tap_o(tap[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sav_top_q <= '0;
      sav_g1_q  <= 1'b0;
    end else if (busy && idx == '0) begin
      sav_top_q <= tap[3][3:0];
      sav_g1_q  <= tap[1][0];
    end
  end

  ks_mix #(.IDX_W(IDX_W)) i_mix (
    .idx_i(idx), .len_i(cfg.len), .wide_i(wide), .z_i,
    .low_i(tap[0][0]), .top3_i(tap[3][3]), .top4_i(tap[3][4]),
    .sav_top_i(sav_top_q), .g1_0_i(tap[1][0]), .g1_1_i(tap[1][1]),
    .sav_g1_i(sav_g1_q), .bit_o(new_bit)
  );

  assign rk_bit_o  = busy ? tap[0][0] : 1'b0;
  assign bit_idx_o = idx;
  assign busy_o    = busy;
  assign zsel_o    = cfg.zsel;

  AST_SAVE_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && idx == '0) |=> (sav_top_q == $past(tap[3][3:0]))); // R6
  AST_LOAD_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && load_i && idx != cfg.len - IDX_W'(1)) |=> busy_o); // R10
endmodule

// File: tb/test_serial_key_sched.sv
`timescale 1ns/1ps
module test_serial_key_sched;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [3:0] cfg_i = '0;
  logic       load_i = 1'b0, key_bit_i = 1'b0, start_i = 1'b0, z_i = 1'b0;
  logic       rk_bit_o, busy_o;
  logic [6:0] bit_idx_o, round_o;
  logic [2:0] zsel_o;
  int total = 0, bad = 0;
  logic [63:0] exp_k [72];

  always #2.5 clk_i = ~clk_i;

  serial_key_sched i_serial_key_sched (.*);

  function automatic int n_of(int c);
    case (c) 1, 2: return 24; 3, 4: return 32; 5, 6: return 48; 7, 8, 9: return 64; default: return 16; endcase
  endfunction
  function automatic int m_of(int c);
    case (c) 1, 3, 6, 8: return 3; 5, 7: return 2; default: return 4; endcase
  endfunction
  function automatic int t_of(int c);
    case (c) 1, 2: return 36; 3: return 42; 4: return 44; 5: return 52; 6: return 54;
      7: return 68; 8: return 69; 9: return 72; default: return 32; endcase
  endfunction
  function automatic int zs_of(int c);
    case (c) 2: return 1; 3, 5, 7: return 2; 4, 6, 8: return 3; 9: return 4; default: return 0; endcase
  endfunction
  function automatic logic [63:0] msk(int n);
    return (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction
  function automatic logic [63:0] rotr(logic [63:0] x, int s, int n);
    return ((x >> s) | (x << (n - s))) & msk(n);
  endfunction
  function automatic logic zb(int r, int c);
    return ((r * 5 + c) % 7) < 3;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    check(busy_o == 1'b0 && rk_bit_o == 1'b0, "R1", "busy/rk after reset", {busy_o, rk_bit_o}, 0);
    check(round_o == '0 && bit_idx_o == '0, "R1", "counters after reset", {round_o, bit_idx_o}, 0);
  endtask

  task automatic test_cfg_table();
    for (int c = 0; c < 16; c++) begin
      @(negedge clk_i);
      cfg_i = 4'(c);
      #1;
      check(zsel_o == 3'(zs_of(c)), "R3", $sformatf("zsel cfg %0d", c), 64'(zsel_o), 64'(zs_of(c)));
    end
  endtask

  task automatic run_case(int c, int seed, bit noise);
    int n = n_of(c), m = m_of(c), t = t_of(c);
    int er = 0, ei = 0, ord_err = 0, cyc = 0;
    logic [63:0] acc = '0;
    @(negedge clk_i);
    cfg_i = 4'(c);
    for (int k = 0; k < m; k++)
      exp_k[k] = ((64'h9E3779B97F4A7C15 * 64'(seed * 5 + k + 1)) ^ (64'hD1B54A32D192ED03 >> k)) & msk(n);
    for (int i = m; i < t; i++) begin
      logic [63:0] tmp;
      tmp = rotr(exp_k[i-1], 3, n);
      if (m == 4) tmp = tmp ^ exp_k[i-3];
      tmp = tmp ^ rotr(tmp, 1, n);
      exp_k[i] = (~exp_k[i-m] ^ tmp ^ 64'(zb(i - m, c)) ^ 64'd3) & msk(n);
    end
    // serial key load, word 0 LSB first
    load_i = 1'b1;
    for (int k = 0; k < m; k++)
      for (int b = 0; b < n; b++) begin
        key_bit_i = exp_k[k][b];
        @(negedge clk_i);
      end
    load_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o && bit_idx_o == 0 && round_o == 0, "R4", "start entry",
          {busy_o, round_o, bit_idx_o}, {1'b1, 14'd0});
    while (busy_o) begin
      if (int'(bit_idx_o) != ei || int'(round_o) != er) ord_err++;
      acc[bit_idx_o[5:0]] = rk_bit_o;
      z_i = (bit_idx_o == 0) ? zb(er, c) : (cyc[0] ^ cyc[3]);
      if (noise) begin
        load_i    = cyc[0];
        key_bit_i = cyc[1];
        start_i   = cyc[2] & cyc[0];
      end
      if (ei == n - 1) begin
        if (er < m)
          check(acc == exp_k[er], "R2 R5", $sformatf("cfg %0d round %0d", c, er), acc, exp_k[er]);
        else if (m == 4)
          check(acc == exp_k[er], "R7 R8", $sformatf("cfg %0d round %0d", c, er), acc, exp_k[er]);
        else
          check(acc == exp_k[er], "R6 R8", $sformatf("cfg %0d round %0d", c, er), acc, exp_k[er]);
        acc = '0;
        ei = 0;
        er++;
      end else begin
        ei++;
      end
      cyc++;
      if (cyc > 5000) break;
      @(negedge clk_i);
    end
    load_i = 1'b0;
    start_i = 1'b0;
    check(ord_err == 0, noise ? "R10" : "R4", "bit/round sequence", 64'(ord_err), 0);
    check(er == t && !busy_o, "R9", "rounds completed", 64'(er), 64'(t));
    check(int'(round_o) == t - 1 && bit_idx_o == 0, "R9", "final round index",
          {round_o, bit_idx_o}, {7'(t - 1), 7'd0});
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    test_reset();
    test_cfg_table();
    run_case(0, 1, 1'b0);
    run_case(1, 2, 1'b0);
    run_case(5, 3, 1'b0);
    run_case(3, 4, 1'b1);
    run_case(9, 5, 1'b0);
    run_case(7, 6, 1'b1);
    run_case(2, 7, 1'b1);
    run_case(8, 8, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule